// File: doc/BRIEF.md
# Banked Bus Cycle Controller

This block runs the external bus cycles of a 16-bit processor. Memory and I/O space are each built from an even byte bank on the low data lane and an odd byte bank on the high data lane. An internal requester offers one cycle at a time: a cycle kind, an address, a byte-or-word flag and write data. The controller walks the bus through its phases. Every cycle starts with one clock that announces the cycle kind on the status pins. The command phase follows and lasts until the external ready input is seen high. The controller then returns read data with a one-clock done pulse.

Banks are selected by the pair formed by an active-low high-bank enable and the least significant address bit. I/O cycles use the same pairs as memory cycles. An external master can take the bus with a hold request. The grant is given only while the bus is idle or at the edge where a cycle finishes. While it holds the grant, the controller parks every bus output in its inactive state and raises a hold acknowledge.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While `rst` is high the phase is idle (0), `rd_n`, `wr_n` and `inta_n` are 1, and `done`, `hold_ack` and `req_accept` are 0. After release the controller starts from idle.
- R2: `phase` is always exactly one of idle=0, status=1, command=2, hold=3.
- R3: The status phase lasts exactly one clock and drives `stat` with the cycle kind. The codes are memory read=0, memory write=1, I/O read=2, I/O write=3, interrupt acknowledge=4 and halt=5, and request codes 6 and 7 run as halt. In every other phase `stat` is 3'b111.
- R4: During the status and command phases, the pair (`bhe_n`,`bus_addr[0]`) is (0,0) for a word, (0,1) for an odd byte and (1,0) for an even byte. (1,1) never appears in those phases.
- R5: Memory and I/O cycles select lanes the same way. A word request at an odd address runs as an odd-byte cycle. Interrupt acknowledge and halt drive address 0 with the even-byte pair. Outside status and command, `bus_addr` is 0 and `bhe_n` is 1.
- R6: Command strobes are driven only in the command phase: `rd_n`=0 for reads, `wr_n`=0 with `bus_doe`=1 for writes, and `inta_n`=0 for interrupt acknowledge. `mio` is 1 in the status and command phases of memory cycles and 0 otherwise. Write data goes out unchanged for a word; a byte is copied onto both lanes.
- R7: The command phase repeats while `ready` is sampled low. The edge that samples it high ends the cycle. The controller then goes to hold if `hold_req` is high, otherwise to status if `req_valid` is high, otherwise to idle.
- R8: A halt cycle ends at the edge that leaves its status phase. It has no command phase and no strobe, and does not wait for `ready`.
- R9: `done` is high for the one clock after each cycle ends, and `rdata` changes only then. `rdata` is `bus_din` for a word; the low lane zero-extended for an even byte or an interrupt acknowledge; the high lane moved to the low byte and zero-extended for an odd byte; and 0 for writes and halts.
- R10: A hold is granted from idle or at a cycle's end, ahead of any waiting request. In hold, `hold_ack` is 1, the strobes are inactive, `bus_doe` and `mio` are 0 and `stat` is passive. The controller returns to idle on the edge where `hold_req` is seen low.
- R11: `req_accept` is high in exactly the clocks whose edge takes the offered request: idle or a cycle's end, `req_valid` high and `hold_req` low. The next phase is status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A cycle request is offered |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | ADDR_W | Byte address of the request |
| req_word | input | 1 | 1 = word transfer, 0 = byte |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_accept | output | 1 | Request taken at this edge |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 16 | Returned read data or vector |
| phase | output | 2 | Current bus phase |
| stat | output | 3 | Cycle status pins |
| bus_addr | output | ADDR_W | Bus address, bit 0 is the lane bit |
| bhe_n | output | 1 | Active-low high bank enable |
| mio | output | 1 | 1 = memory space |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| inta_n | output | 1 | Interrupt acknowledge strobe |
| bus_doe | output | 1 | Write data drive enable |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| ready | input | 1 | Command phase may end |
| hold_req | input | 1 | External master asks for the bus |
| hold_ack | output | 1 | Bus handed over |

## Verification
A wrong phase shows up within one clock: the next sampled `phase` differs, and the strobes, `stat` or `hold_ack` appear in the wrong clock. A wrongly latched kind or lane becomes visible in the status clock of that same cycle, through `stat`, `mio` or the (`bhe_n`,`bus_addr[0]`) pair. A wrong read-data steering rule stays hidden until the `done` clock, when `rdata` carries the wrong lane. The bench therefore compares every output on every clock against an independent model.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int LANE_W = 8;
    localparam int DATA_W = 2 * LANE_W;

    typedef enum logic [2:0] {
        CK_MEMRD = 3'd0,
        CK_MEMWR = 3'd1,
        CK_IORD  = 3'd2,
        CK_IOWR  = 3'd3,
        CK_INTA  = 3'd4,
        CK_HALT  = 3'd5
    } cyc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STAT = 2'd1,
        PH_CMD  = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        LN_WORD = 2'd0,
        LN_EVEN = 2'd1,
        LN_ODD  = 2'd2
    } lane_e;

    localparam logic [2:0] STAT_PASSIVE = 3'b111;

    typedef struct packed {
        cyc_kind_e          kind;
        lane_e              lane;
        logic [DATA_W-1:0]  wdata;
    } cyc_req_t;

    // Unused codes fall back to a halt cycle.
    function automatic cyc_kind_e norm_kind(input logic [2:0] code);
        if (code > 3'd5) return CK_HALT;
        return cyc_kind_e'(code);
    endfunction

    function automatic logic no_addr(input cyc_kind_e k);
        return (k == CK_INTA) || (k == CK_HALT);
    endfunction

    function automatic logic is_read(input cyc_kind_e k);
        return (k == CK_MEMRD) || (k == CK_IORD);
    endfunction

    function automatic logic is_write(input cyc_kind_e k);
        return (k == CK_MEMWR) || (k == CK_IOWR);
    endfunction

    function automatic logic is_mem(input cyc_kind_e k);
        return (k == CK_MEMRD) || (k == CK_MEMWR);
    endfunction

    // Misaligned words are not split: the odd address wins.
    function automatic lane_e pick_lane(input cyc_kind_e k, input logic word, input logic a0);
        if (no_addr(k)) return LN_EVEN;
        if (a0)         return LN_ODD;
        if (word)       return LN_WORD;
        return LN_EVEN;
    endfunction

    // Returns {bhe_n, a0}.
    function automatic logic [1:0] lane_pins(input lane_e l);
        case (l)
            LN_WORD: return 2'b00;
            LN_ODD:  return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] place_wdata(input lane_e l, input logic [DATA_W-1:0] w);
        if (l == LN_WORD) return w;
        return {2{w[LANE_W-1:0]}};
    endfunction

endpackage

// File: rtl/bcc_sequencer.sv
module bcc_sequencer
    import bcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   hold_req,
    input  logic   ready,
    input  logic   cur_halt,
    output phase_e phase,
    output logic   accept,
    output logic   cyc_end
);

    phase_e ph_q, ph_d;
    logic   free;

    always_comb begin
        cyc_end = ((ph_q == PH_CMD) && ready) || ((ph_q == PH_STAT) && cur_halt);
        free    = (ph_q == PH_IDLE) || cyc_end;
        accept  = free && !hold_req && req_valid;
        ph_d    = ph_q;
        if (free) begin
            if (hold_req)       ph_d = PH_HOLD;
            else if (req_valid) ph_d = PH_STAT;
            else                ph_d = PH_IDLE;
        end else begin
            case (ph_q)
                PH_STAT: ph_d = PH_CMD;
                PH_HOLD: if (!hold_req) ph_d = PH_IDLE;
                default: ph_d = ph_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    assign phase = ph_q;

endmodule

// File: rtl/bcc_req_latch.sv
module bcc_req_latch
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [2:0]         req_kind,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_word,
    input  logic [DATA_W-1:0]  req_wdata,
    output cyc_req_t           cur,
    output logic [ADDR_W-1:0]  cur_addr
);

    cyc_kind_e k_in;

    always_comb k_in = norm_kind(req_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.kind  <= CK_MEMRD;
            cur.lane  <= LN_EVEN;
            cur.wdata <= '0;
            cur_addr  <= '0;
        end else if (accept) begin
            cur.kind  <= k_in;
            cur.lane  <= pick_lane(k_in, req_word, req_addr[0]);
            cur.wdata <= req_wdata;
            cur_addr  <= no_addr(k_in) ? '0 : req_addr;
        end
    end

endmodule

// File: rtl/bcc_pin_drive.sv
module bcc_pin_drive
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  phase_e             phase,
    input  cyc_req_t           cur,
    input  logic [ADDR_W-1:0]  cur_addr,
    output logic [2:0]         stat,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bhe_n,
    output logic               mio,
    output logic               rd_n,
    output logic               wr_n,
    output logic               inta_n,
    output logic               bus_doe,
    output logic [DATA_W-1:0]  bus_dout,
    output logic               hold_ack
);

    logic       active, cmd;
    logic [1:0] pins;

    always_comb begin
        active   = (phase == PH_STAT) || (phase == PH_CMD);
        cmd      = (phase == PH_CMD);
        pins     = lane_pins(cur.lane);
        stat     = (phase == PH_STAT) ? cur.kind : STAT_PASSIVE;
        bus_addr = active ? {cur_addr[ADDR_W-1:1], pins[0]} : '0;
        bhe_n    = active ? pins[1] : 1'b1;
        mio      = active && is_mem(cur.kind);
        rd_n     = !(cmd && is_read(cur.kind));
        wr_n     = !(cmd && is_write(cur.kind));
        inta_n   = !(cmd && (cur.kind == CK_INTA));
        bus_doe  = cmd && is_write(cur.kind);
        bus_dout = bus_doe ? place_wdata(cur.lane, cur.wdata) : '0;
        hold_ack = (phase == PH_HOLD);
    end

endmodule

// File: rtl/bcc_capture.sv
module bcc_capture
    import bcc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cyc_end,
    input  cyc_kind_e          kind,
    input  lane_e              lane,
    input  logic [DATA_W-1:0]  bus_din,
    output logic               done,
    output logic [DATA_W-1:0]  rdata
);

    logic [LANE_W-1:0] lanes [2];
    logic [DATA_W-1:0] steered;
    logic              takes_data;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lanes[g] = bus_din[g*LANE_W +: LANE_W];
    end

    always_comb begin
        takes_data = is_read(kind) || (kind == CK_INTA);
        case (lane)
            LN_WORD: steered = bus_din;
            LN_ODD:  steered = {{LANE_W{1'b0}}, lanes[1]};
            default: steered = {{LANE_W{1'b0}}, lanes[0]};
        endcase
        if (!takes_data) steered = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= cyc_end;
            if (cyc_end) rdata <= steered;
        end
    end

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [2:0]         req_kind,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_word,
    input  logic [15:0]        req_wdata,
    output logic               req_accept,
    output logic               done,
    output logic [15:0]        rdata,
    output logic [1:0]         phase,
    output logic [2:0]         stat,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bhe_n,
    output logic               mio,
    output logic               rd_n,
    output logic               wr_n,
    output logic               inta_n,
    output logic               bus_doe,
    output logic [15:0]        bus_dout,
    input  logic [15:0]        bus_din,
    input  logic               ready,
    input  logic               hold_req,
    output logic               hold_ack
);

    phase_e             ph;
    cyc_req_t           cur;
    logic [ADDR_W-1:0]  cur_addr;
    logic               cyc_end;
    logic               cur_halt;

    assign cur_halt = (cur.kind == CK_HALT);
    assign phase    = ph;

    bcc_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .hold_req  (hold_req),
        .ready     (ready),
        .cur_halt  (cur_halt),
        .phase     (ph),
        .accept    (req_accept),
        .cyc_end   (cyc_end)
    );

    bcc_req_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .accept    (req_accept),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_word  (req_word),
        .req_wdata (req_wdata),
        .cur       (cur),
        .cur_addr  (cur_addr)
    );

    bcc_pin_drive #(.ADDR_W(ADDR_W)) u_pins (
        .phase    (ph),
        .cur      (cur),
        .cur_addr (cur_addr),
        .stat     (stat),
        .bus_addr (bus_addr),
        .bhe_n    (bhe_n),
        .mio      (mio),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .inta_n   (inta_n),
        .bus_doe  (bus_doe),
        .bus_dout (bus_dout),
        .hold_ack (hold_ack)
    );

    bcc_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .cyc_end (cyc_end),
        .kind    (cur.kind),
        .lane    (cur.lane),
        .bus_din (bus_din),
        .done    (done),
        .rdata   (rdata)
    );

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] phase,
    input logic [2:0] stat,
    input logic       bus_a0,
    input logic       bhe_n,
    input logic       mio,
    input logic       rd_n,
    input logic       wr_n,
    input logic       inta_n,
    input logic       bus_doe,
    input logic       ready,
    input logic       hold_req,
    input logic       hold_ack,
    input logic       req_accept
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (phase == 2'd0 && !hold_ack));

    // R3
    stat_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd1 && stat != 3'd5) |=> phase == 2'd2);

    // R3
    stat_passive_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd1) |-> stat == 3'b111);

    // R4
    lane_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd1 || phase == 2'd2) |-> !(bhe_n && bus_a0));

    // R6
    strobe_in_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n || !inta_n) |-> (phase == 2'd2 && $onehot0({!rd_n, !wr_n, !inta_n})));

    // R7
    wait_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2 && !ready) |=> phase == 2'd2);

    // R8
    halt_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd1 && stat == 3'd5) |=> phase != 2'd2);

    // R10
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> (rd_n && wr_n && inta_n && !bus_doe && !mio && bhe_n && stat == 3'b111));

    // R10
    hold_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_ack && !hold_req) |=> phase == 2'd0);

    // R11
    accept_next_chk: assert property (@(posedge clk) disable iff (rst)
        req_accept |=> phase == 2'd1);

endmodule

bind bus_cycle_ctrl bcc_checker u_bcc_chk (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .stat       (stat),
    .bus_a0     (bus_addr[0]),
    .bhe_n      (bhe_n),
    .mio        (mio),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .inta_n     (inta_n),
    .bus_doe    (bus_doe),
    .ready      (ready),
    .hold_req   (hold_req),
    .hold_ack   (hold_ack),
    .req_accept (req_accept)
);

// File: tb/test_bus_cycle_ctrl.sv
module test_bus_cycle_ctrl;

    localparam int AW = 20;
    localparam int NREQ = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_kind = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_word = 1'b0;
    logic [15:0]   req_wdata = '0;
    logic          req_accept, done;
    logic [15:0]   rdata;
    logic [1:0]    phase;
    logic [2:0]    stat;
    logic [AW-1:0] bus_addr;
    logic          bhe_n, mio, rd_n, wr_n, inta_n, bus_doe;
    logic [15:0]   bus_dout, bus_din;
    logic          ready = 1'b0;
    logic          hold_req = 1'b0;
    logic          hold_ack;

    always #10 clk = ~clk;

    function automatic logic [15:0] mem_model(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] ^ 8'hC3};
    endfunction

    assign bus_din = mem_model(bus_addr);

    bus_cycle_ctrl #(.ADDR_W(AW)) i_bus_cycle_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
        .req_accept(req_accept), .done(done), .rdata(rdata), .phase(phase),
        .stat(stat), .bus_addr(bus_addr), .bhe_n(bhe_n), .mio(mio),
        .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .bus_doe(bus_doe),
        .bus_dout(bus_dout), .bus_din(bus_din), .ready(ready),
        .hold_req(hold_req), .hold_ack(hold_ack)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // request script
    logic [2:0]    t_kind [NREQ];
    logic [AW-1:0] t_addr [NREQ];
    logic          t_word [NREQ];
    logic [15:0]   t_wd   [NREQ];

    initial begin
        t_kind[0]=0;  t_addr[0]=20'h01000; t_word[0]=1; t_wd[0]=16'h0;
        t_kind[1]=0;  t_addr[1]=20'h01003; t_word[1]=0; t_wd[1]=16'h0;
        t_kind[2]=1;  t_addr[2]=20'h02004; t_word[2]=1; t_wd[2]=16'hBEEF;
        t_kind[3]=1;  t_addr[3]=20'h02005; t_word[3]=0; t_wd[3]=16'h993C;
        t_kind[4]=2;  t_addr[4]=20'h00060; t_word[4]=0; t_wd[4]=16'h0;
        t_kind[5]=3;  t_addr[5]=20'h00061; t_word[5]=0; t_wd[5]=16'h115A;
        t_kind[6]=4;  t_addr[6]=20'h0ABCD; t_word[6]=1; t_wd[6]=16'h0;
        t_kind[7]=5;  t_addr[7]=20'h0FFFF; t_word[7]=1; t_wd[7]=16'h0;
        t_kind[8]=5;  t_addr[8]=20'h00000; t_word[8]=0; t_wd[8]=16'h0;
        t_kind[9]=0;  t_addr[9]=20'h01007; t_word[9]=1; t_wd[9]=16'h0;
        t_kind[10]=2; t_addr[10]=20'h00080; t_word[10]=1; t_wd[10]=16'h0;
        t_kind[11]=6; t_addr[11]=20'h00123; t_word[11]=0; t_wd[11]=16'h0;
        t_kind[12]=1; t_addr[12]=20'h03000; t_word[12]=0; t_wd[12]=16'h4477;
        t_kind[13]=0; t_addr[13]=20'h03002; t_word[13]=0; t_wd[13]=16'h0;
        t_kind[14]=3; t_addr[14]=20'h00044; t_word[14]=1; t_wd[14]=16'h1234;
        t_kind[15]=7; t_addr[15]=20'h04001; t_word[15]=1; t_wd[15]=16'h0;
    end

    // reference model: phase 0 idle, 1 status, 2 command, 3 hold; lane 0 word, 1 even, 2 odd
    int            qi = 0;
    int            mph = 0;
    int            mk = 0;
    int            mlane = 1;
    logic [AW-1:0] maddr = '0;
    logic [15:0]   mwd = '0;
    logic          mdone = 1'b0;
    logic [15:0]   mrd = '0;

    function automatic logic [15:0] model_rdata();
        logic [15:0] d;
        d = mem_model(maddr);
        if (!(mk == 0 || mk == 2 || mk == 4)) return 16'h0;
        if (mlane == 0) return d;
        if (mlane == 2) return {8'h00, d[15:8]};
        return {8'h00, d[7:0]};
    endfunction

    function automatic logic model_accept();
        logic fin;
        fin = (mph == 2 && ready) || (mph == 1 && mk == 5);
        return (mph == 0 || fin) && !hold_req && req_valid;
    endfunction

    always @(posedge clk) begin
        logic fin, acc;
        if (rst) begin
            mph = 0; mdone = 0; mrd = '0;
        end else begin
            fin = (mph == 2 && ready) || (mph == 1 && mk == 5);
            acc = model_accept();
            mdone = fin;
            if (fin) mrd = model_rdata();
            if (mph == 0 || fin) begin
                if (hold_req) mph = 3;
                else if (req_valid) mph = 1;
                else mph = 0;
            end else if (mph == 1) mph = 2;
            else if (mph == 3 && !hold_req) mph = 0;
            if (acc) begin
                mk = (req_kind > 3'd5) ? 5 : int'(req_kind);
                mwd = req_wdata;
                if (mk == 4 || mk == 5) begin mlane = 1; maddr = '0; end
                else begin
                    maddr = req_addr;
                    if (req_addr[0]) mlane = 2;
                    else if (req_word) mlane = 0;
                    else mlane = 1;
                end
                qi++;
            end
        end
    end

    // stimulus, changed just after each rising edge
    int          cyc = 0;
    logic [7:0]  lfsr = 8'h9D;

    always @(posedge clk) begin
        #2;
        cyc++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ready = lfsr[0] | lfsr[3];
        hold_req = (cyc >= 8 && cyc < 12) || (cyc >= 40 && cyc < 45) ||
                   (cyc >= 90 && cyc < 92) || (cyc >= 150 && cyc < 154);
        req_valid = (qi < NREQ) && cyc >= 15 && !(cyc >= 140 && cyc < 160);
        if (qi < NREQ) begin
            req_kind = t_kind[qi]; req_addr = t_addr[qi];
            req_word = t_word[qi]; req_wdata = t_wd[qi];
        end
    end

    // compare on every clock, away from the rising edge
    always @(negedge clk) begin
        logic          act, cmdp;
        logic [AW-1:0] e_addr;
        logic          e_bhe;
        logic [15:0]   e_dout;
        if (rst) begin
            chk("R1 phase in reset", 32'(phase), 0);
            chk("R1 strobes in reset", {29'd0, rd_n, wr_n, inta_n}, 32'h7);
            chk("R1 done/hold_ack/accept in reset", {29'd0, done, hold_ack, req_accept}, 0);
        end else begin
            act  = (mph == 1 || mph == 2);
            cmdp = (mph == 2);
            e_addr = act ? maddr : '0;
            e_bhe  = act ? (mlane == 1) : 1'b1;
            e_dout = '0;
            if (cmdp && (mk == 1 || mk == 3)) e_dout = (mlane == 0) ? mwd : {2{mwd[7:0]}};
            chk("R2 R7 R8 phase", 32'(phase), 32'(mph));
            chk("R3 R8 stat", 32'(stat), (mph == 1) ? 32'(mk) : 32'h7);
            chk("R4 R5 lane pair and address", {11'd0, bhe_n, bus_addr}, {11'd0, e_bhe, e_addr});
            chk("R6 strobes and mio", {26'd0, rd_n, wr_n, inta_n, bus_doe, mio},
                {26'd0, !(cmdp && (mk == 0 || mk == 2)), !(cmdp && (mk == 1 || mk == 3)),
                 !(cmdp && mk == 4), cmdp && (mk == 1 || mk == 3), act && (mk == 0 || mk == 1)});
            chk("R6 write data lanes", 32'(bus_dout), 32'(e_dout));
            chk("R9 done pulse", 32'(done), 32'(mdone));
            chk("R9 rdata", 32'(rdata), 32'(mrd));
            chk("R10 hold_ack", 32'(hold_ack), 32'(mph == 3));
            chk("R11 req_accept", 32'(req_accept), 32'(model_accept()));
        end
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        begin : run
            for (int i = 0; i < 5000; i++) begin
                @(posedge clk);
                if (qi == NREQ && mph == 0) disable run;
            end
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d requests", qi, NREQ);
        end
        repeat (10) @(posedge clk);
        @(negedge clk);
        #1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule